// File: doc/BRIEF.md
# Wake-Up Event Aggregator

This block gathers 32 wake-up sources into pending flags and turns those flags into interrupt lines and a sleep-exit request. Lines 0 to 29 are external pin events, line 30 is the real-time-clock interrupt and line 31 is the USB resume event. It runs from the always-on low-frequency clock, so it keeps watching its inputs while the rest of the device is asleep.

Each line has its own enable bit and edge-polarity bit. An enabled edge of the chosen polarity sets the line's pending flag. The flag stays set until software pulses a clear with a 1 in that bit position. A software trigger can set any pending flag directly, which lets software test the interrupt path.

The pending flags drive several outputs:
- one interrupt that is the OR of all 32 flags;
- four group interrupts, each the OR of eight consecutive flags, each wired to the interrupt controller as a separate source;
- a wake request for the clock and power controller.

Top module: `wkup_aggr`

## Requirements
- R1: Bit k of `src_i` is line k. Bits 0..29 are pins, bit 30 is the RTC interrupt and bit 31 is USB resume. Each line is synchronised by two flops on `clk`. An enabled edge applied before rising clock edge E0 is first visible on `pend_o` after edge E2, and is not visible after E1.
- R2: While `line_en_i[k]` is 0, no edge on line k sets pending bit k.
- R3: `rise_sel_i[k]`=1 selects rising edges and 0 selects falling edges. An edge of the other polarity does not set the bit.
- R4: A 1 in `clr_i[k]` for one cycle clears pending bit k at the next clock edge. Bits whose `clr_i` bit is 0 are left unchanged.
- R5: A pending bit changes only when a set (edge or trigger) or a clear acts on it. Once set, it holds while the source stays still.
- R6: When a set (edge or trigger) and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: A 1 in `swtrig_i[k]` sets pending bit k at the next clock edge, whatever the value of `line_en_i[k]`.
- R8: `irq_grp_o[g]` is the OR of pending bits 8g..8g+7, for g = 0..3.
- R9: `irq_any_o` is the OR of all 32 pending bits.
- R10: `wake_req_o` is high in exactly the cycles in which at least one pending bit is set.
- R11: A synchronous reset clears all pending bits. After reset `irq_any_o`, `irq_grp_o` and `wake_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous wake sources (pins 0..29, RTC 30, USB resume 31) |
| line_en_i | input | 32 | Per-line enable |
| rise_sel_i | input | 32 | Per-line polarity: 1 rising, 0 falling |
| clr_i | input | 32 | Write-one-to-clear strobe for pending bits |
| swtrig_i | input | 32 | Software set strobe for pending bits |
| pend_o | output | 32 | Pending flags |
| irq_any_o | output | 1 | OR of all pending flags |
| irq_grp_o | output | 4 | OR of each group of eight pending flags |
| wake_req_o | output | 1 | Sleep-exit request |

## Verification
On every cycle, the assertions check four things:
- a set always wins over a clear on the same bit;
- a clear removes every bit it targets when no set competes;
- untouched pending bits never move;
- the wake request, the OR output and the group outputs agree with the pending vector.

Only the bench scenarios can show the rest:
- the exact three-edge latency through the synchroniser and edge detector;
- the polarity choice per line;
- that disabled lines stay silent;
- where each group boundary falls.

Those scenarios include mixed rising and falling patterns and an edge that arrives in the same cycle as a clear.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int unsigned WK_LINES     = 32;
    localparam int unsigned WK_GRP_W     = 8;
    localparam int unsigned WK_SYNC_LEN  = 2;
    localparam int unsigned WK_RTC_IDX   = 30;
    localparam int unsigned WK_USB_IDX   = 31;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_pol_e;

    typedef struct packed {
        logic      en;
        edge_pol_e pol;
    } line_cfg_t;

    typedef struct packed {
        logic now;
        logic prev;
    } line_smp_t;

    // Qualified edge for one line: enabled and of the chosen polarity.
    function automatic logic edge_hit(line_cfg_t c, line_smp_t s);
        logic rose;
        logic dropped;
        rose    = s.now & ~s.prev;
        dropped = ~s.now & s.prev;
        return c.en & ((c.pol == EDGE_RISE) ? rose : dropped);
    endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge
    import wkup_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        line_cfg_t cfg;
        line_smp_t smp;
        assign cfg = '{en: en_i[i], pol: edge_pol_e'(rise_sel_i[i])};
        assign smp = '{now: lvl_i[i], prev: prev_q[i]};
        assign hit_o[i] = edge_hit(cfg, smp);
    end
endmodule

// File: rtl/wkup_pend.sv
module wkup_pend #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit_i,
    input  logic [W-1:0] trig_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] set_vec;
    logic [W-1:0] pend_q;

    assign set_vec = hit_i | trig_i;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | set_vec;
    end

    assign pend_o = pend_q;

    // R6: every bit that was set in the previous cycle is pending now
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R4: a clear with no competing set empties the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_vec) != '0) |=> ((pend_q & $past(clr_i & ~set_vec)) == '0));

    // R5: untouched bits keep their value
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(clr_i | set_vec)) == '0));
endmodule

// File: rtl/wkup_grp.sv
module wkup_grp #(
    parameter int unsigned W  = 32,
    parameter int unsigned GW = 8
) (
    input  logic [W-1:0]      pend_i,
    output logic [W/GW-1:0]   grp_o,
    output logic              any_o
);
    localparam int unsigned NG = W / GW;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_o[g] = |pend_i[g*GW +: GW];
    end

    assign any_o = |pend_i;
endmodule

// File: rtl/wkup_aggr.sv
module wkup_aggr
    import wkup_pkg::*;
#(
    parameter int unsigned NUM_SRC     = WK_LINES,
    parameter int unsigned GRP_W       = WK_GRP_W,
    parameter int unsigned SYNC_STAGES = WK_SYNC_LEN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_i,
    input  logic [NUM_SRC-1:0]         line_en_i,
    input  logic [NUM_SRC-1:0]         rise_sel_i,
    input  logic [NUM_SRC-1:0]         clr_i,
    input  logic [NUM_SRC-1:0]         swtrig_i,
    output logic [NUM_SRC-1:0]         pend_o,
    output logic                       irq_any_o,
    output logic [NUM_SRC/GRP_W-1:0]   irq_grp_o,
    output logic                       wake_req_o
);
    localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;

    logic [NUM_SRC-1:0] lvl_s;
    logic [NUM_SRC-1:0] hit_s;
    logic [NUM_GRP-1:0] grp_s;

    wkup_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (lvl_s)
    );

    wkup_edge #(.W(NUM_SRC)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .lvl_i      (lvl_s),
        .en_i       (line_en_i),
        .rise_sel_i (rise_sel_i),
        .hit_o      (hit_s)
    );

    wkup_pend #(.W(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit_s),
        .trig_i (swtrig_i),
        .clr_i  (clr_i),
        .pend_o (pend_o)
    );

    wkup_grp #(.W(NUM_SRC), .GW(GRP_W)) u_grp (
        .pend_i (pend_o),
        .grp_o  (grp_s),
        .any_o  (irq_any_o)
    );

    assign irq_grp_o  = grp_s;
    // Wake request built from the group lines, independent of the full OR.
    assign wake_req_o = |grp_s;

    // R10: wake request agrees with the full OR
    p_wake_any_r10: assert property (@(posedge clk) disable iff (rst)
        wake_req_o == irq_any_o);

    // R8: a single pending bit lights exactly one group line
    p_one_grp_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend_o) == 1) |-> ($countones(irq_grp_o) == 1));

    // R9/R11: no pending bit means all interrupt outputs are quiet
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_o == '0) |-> (!irq_any_o && (irq_grp_o == '0)));
endmodule

// File: tb/wkup_aggr_tb.sv
module wkup_aggr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [31:0] en  = '0;
    logic [31:0] rs  = '0;
    logic [31:0] clr = '0;
    logic [31:0] trg = '0;
    logic [31:0] pend;
    logic        any;
    logic [3:0]  grp;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wkup_aggr dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .line_en_i  (en),
        .rise_sel_i (rs),
        .clr_i      (clr),
        .swtrig_i   (trg),
        .pend_o     (pend),
        .irq_any_o  (any),
        .irq_grp_o  (grp),
        .wake_req_o (wake)
    );

    // {enable, rise select, new source level, expected pending}
    localparam logic [127:0] VEC [6] = '{
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_00FF},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000F, 32'h0000_00F0},
        {32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_000F, 32'h0000_0000},
        {32'hFFFF_0000, 32'h0000_0000, 32'h0000_000F, 32'hFFFF_0000},
        {32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'hC000_0005, 32'h8000_0000},
        {32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0000, 32'h4000_0005}
    };

    localparam int BND [8] = '{0, 7, 8, 15, 16, 23, 24, 31};

    function automatic logic [3:0] grp_of(logic [31:0] p);
        logic [3:0] g;
        for (int k = 0; k < 4; k++) g[k] = |p[k*8 +: 8];
        return g;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req, logic [31:0] exp);
        check(req, pend, exp);
        check({req, " grp"}, {28'd0, grp}, {28'd0, grp_of(exp)});
        check({req, " any"}, {31'd0, any}, {31'd0, |exp});
        check({req, " wake"}, {31'd0, wake}, {31'd0, |exp});
    endtask

    task automatic clear_all();
        clr = '1;
        @(negedge clk);
        clr = '0;
    endtask

    task automatic pulse_trig(logic [31:0] m);
        trg = m;
        @(negedge clk);
        trg = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R11 reset", 32'h0);

        // Table: R1/R2/R3 edge patterns, R5 hold, R4 clear
        for (int v = 0; v < 6; v++) begin
            en = VEC[v][127:96];
            rs = VEC[v][95:64];
            @(negedge clk);
            src = VEC[v][63:32];
            repeat (3) @(posedge clk);
            @(negedge clk);
            check_outs($sformatf("R3 R2 vec%0d", v), VEC[v][31:0]);
            repeat (2) @(negedge clk);
            check($sformatf("R5 hold vec%0d", v), pend, VEC[v][31:0]);
            clear_all();
            check($sformatf("R4 clear vec%0d", v), pend, 32'h0);
        end

        // R1 latency: RTC line 30
        en = '1; rs = '1;
        src = 32'h4000_0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 not after E1", pend, 32'h0);
        @(negedge clk);
        check("R1 after E2", pend, 32'h4000_0000);

        // R4 clear of other bit has no effect, then real clear
        clr = 32'h0000_0020;
        @(negedge clk);
        clr = '0;
        check("R4 other bit", pend, 32'h4000_0000);
        clr = 32'h4000_0000;
        @(negedge clk);
        clr = '0;
        check_outs("R4 clear bit30", 32'h0);

        // R6 edge meets clear: USB resume line 31
        pulse_trig(32'h8000_0000);
        check("R7 trig bit31", pend, 32'h8000_0000);
        src = 32'hC000_0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr = 32'h8000_0000;
        @(negedge clk);
        clr = '0;
        check("R6 edge beats clear", pend, 32'h8000_0000);
        clear_all();
        check("R6 cleared", pend, 32'h0);

        // R6 trigger meets clear
        trg = 32'h0000_0200;
        clr = 32'h0000_0200;
        @(negedge clk);
        trg = '0;
        clr = '0;
        check("R6 trig beats clear", pend, 32'h0000_0200);
        clear_all();

        // R7 trigger with line disabled
        en = '0;
        pulse_trig(32'h0000_0008);
        check_outs("R7 trig disabled", 32'h0000_0008);
        clear_all();

        // R8/R9/R10 group boundaries
        for (int b = 0; b < 8; b++) begin
            pulse_trig(32'h1 << BND[b]);
            check_outs($sformatf("R8 R9 R10 bit%0d", BND[b]), 32'h1 << BND[b]);
            clear_all();
            check_outs($sformatf("R10 idle bit%0d", BND[b]), 32'h0);
        end

        // R11 reset in mid-run
        pulse_trig(32'h0F0F_F0F0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_outs("R11 mid reset", 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule